// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder with Selectable Carry Tree

This block adds two N-bit unsigned operands and a carry-in. It returns an N-bit sum and a carry-out. All carries come from a parallel-prefix network. A parameter chosen at build time selects the wiring of that network: Kogge-Stone, Brent-Kung, Sklansky or Han-Carlson. Every tree is made only from two shared cells. One cell merges a group generate alone. The other merges both group generate and group propagate. All four trees compute the same function and differ only in stage count, fanout and cell count.

Each bit first forms a generate (AND) and an OR-propagate for the carry tree, plus an XOR half-sum for the final sum. The carry-in is merged into bit 0's generate. Every prefix therefore ends at the carry-in, and the network output at position i is the carry into bit i+1. An optional output register can be enabled so that the timing of the four trees can be compared in a clocked setting.

Top module: `ppx_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `cin_i`) modulo 2^N.
- R2: `cout_o` equals bit N of the (N+1)-bit value `a_i` + `b_i` + `cin_i`.
- R3: For any input, the four topologies produce the same sum and carry-out. The encoding of `TOPO` is 0 Kogge-Stone, 1 Brent-Kung, 2 Sklansky, 3 Han-Carlson.
- R4: The block works at N = 8, 16 and 32. N must be a power of two, at least 4.
- R5: The localparam `PFX_STAGES` gives the prefix depth: log2(N) for Kogge-Stone and Sklansky, 2·log2(N)−1 for Brent-Kung, and log2(N)+1 for Han-Carlson.
- R6: A carry ripples through the full width. All-ones plus zero with carry-in 1 gives sum 0 and carry-out 1. Complementary alternating patterns (0101…/1010…) with carry-in 1 also give sum 0 and carry-out 1.
- R7: With `OUT_REG` = 0 the block is purely combinational. The outputs follow the inputs with no clock edge in between, and `clk_i`/`rst_ni` have no effect.
- R8: With `OUT_REG` = 1 the outputs show the result of the inputs sampled at the previous rising edge of `clk_i`. The outputs do not change between edges.
- R9: With `OUT_REG` = 1, driving `rst_ni` low clears `sum_o` and `cout_o` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | N | Sum, modulo 2^N |
| cout_o | output | 1 | Carry-out |

## Verification
The clocked checks assume that the operands and the carry-in are stable around each rising edge of `clk_i`. In the combinational variant they also assume the outputs have settled by that edge. The bench meets both assumptions by changing inputs only on falling edges. The registered-latency check also assumes that the reset has been high for at least one earlier edge. The bench holds `rst_ni` low across the first edges and only starts the latency comparisons after release.

// File: rtl/ppx_pkg.sv
package ppx_pkg;

  typedef enum logic [1:0] {
    TOPO_KS = 2'd0,
    TOPO_BK = 2'd1,
    TOPO_SK = 2'd2,
    TOPO_HC = 2'd3
  } topo_e;

  // Prefix depth for a topology at width 2**lg
  function automatic int pfx_levels(topo_e t, int lg);
    case (t)
      TOPO_BK: return 2 * lg - 1;
      TOPO_HC: return lg + 1;
      default: return lg;
    endcase
  endfunction

  // Lower operand index feeding node i at level lvl, -1 when the node passes through
  function automatic int pfx_src(topo_e t, int lg, int lvl, int i);
    int d;
    case (t)
      TOPO_KS: begin
        d = 1 << lvl;
        return (i >= d) ? i - d : -1;
      end
      TOPO_SK: begin
        if (((i >> lvl) & 1) == 1) return ((i >> lvl) << lvl) - 1;
        return -1;
      end
      TOPO_BK: begin
        if (lvl < lg) begin
          d = 1 << lvl;
          return (((i + 1) % (2 * d)) == 0) ? i - d : -1;
        end else begin
          d = 1 << (2 * lg - 2 - lvl);
          return ((((i + 1) % (2 * d)) == d) && (i >= 2 * d)) ? i - d : -1;
        end
      end
      default: begin
        if (lvl == 0) return ((i % 2) == 1) ? i - 1 : -1;
        if (lvl == lg) return (((i % 2) == 0) && (i >= 2)) ? i - 1 : -1;
        d = 1 << lvl;
        return (((i % 2) == 1) && (i >= d)) ? i - d : -1;
      end
    endcase
  endfunction

  // Lowest bit covered by node i after level lvl
  function automatic int pfx_low(topo_e t, int lg, int lvl, int i);
    int cur;
    int s;
    cur = i;
    for (int l = lvl; l >= 0; l--) begin
      s = pfx_src(t, lg, l, cur);
      if (s >= 0) cur = s;
    end
    return cur;
  endfunction

endpackage

// File: rtl/ppx_cells.sv
module ppx_black_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  input  logic p_lo_i,
  output logic g_o,
  output logic p_o
);
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
  assign p_o = p_hi_i & p_lo_i;
endmodule

module ppx_gray_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  output logic g_o
);
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
endmodule

// File: rtl/ppx_pg.sv
module ppx_pg #(
  parameter int N = 32
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] g_o,
  output logic [N-1:0] p_o,
  output logic [N-1:0] d_o
);
  logic [N-1:0] g_raw;

  assign g_raw = a_i & b_i;
  assign p_o   = a_i | b_i;
  assign d_o   = a_i ^ b_i;

  // carry-in merged into bit 0 so every prefix ends at the carry-in
  assign g_o[0] = g_raw[0] | (p_o[0] & cin_i);
  if (N > 1) begin : g_upper
    assign g_o[N-1:1] = g_raw[N-1:1];
  end
endmodule

// File: rtl/ppx_tree.sv
module ppx_tree #(
  parameter int            N    = 32,
  parameter ppx_pkg::topo_e TOPO = ppx_pkg::TOPO_KS
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  output logic [N-1:0] c_o
);
  localparam int LG = $clog2(N);
  localparam int LV = ppx_pkg::pfx_levels(TOPO, LG);

  logic [N-1:0] g_l [LV+1];
  logic [N-1:0] p_l [LV+1];

  assign g_l[0] = g_i;
  assign p_l[0] = p_i;

  for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_bit
      localparam int S = ppx_pkg::pfx_src(TOPO, LG, lv, i);
      if (S < 0) begin : g_pass
        assign g_l[lv+1][i] = g_l[lv][i];
        assign p_l[lv+1][i] = p_l[lv][i];
      end else if (ppx_pkg::pfx_low(TOPO, LG, lv, i) == 0) begin : g_gray
        ppx_gray_cell u_cell (
          .g_hi_i(g_l[lv][i]),
          .p_hi_i(p_l[lv][i]),
          .g_lo_i(g_l[lv][S]),
          .g_o   (g_l[lv+1][i])
        );
        assign p_l[lv+1][i] = 1'b0;
      end else begin : g_black
        ppx_black_cell u_cell (
          .g_hi_i(g_l[lv][i]),
          .p_hi_i(p_l[lv][i]),
          .g_lo_i(g_l[lv][S]),
          .p_lo_i(p_l[lv][S]),
          .g_o   (g_l[lv+1][i]),
          .p_o   (p_l[lv+1][i])
        );
      end
    end
  end

  assign c_o = g_l[LV];

  logic unused_p;
  assign unused_p = ^p_l[LV];
endmodule

// File: rtl/ppx_sum.sv
module ppx_sum #(
  parameter int N = 32
) (
  input  logic [N-1:0] d_i,
  input  logic [N-1:0] c_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  logic [N-1:0] c_in_bit;

  if (N > 1) begin : g_shift
    assign c_in_bit = {c_i[N-2:0], cin_i};
  end else begin : g_one
    assign c_in_bit = cin_i;
  end

  assign sum_o  = d_i ^ c_in_bit;
  assign cout_o = c_i[N-1];
endmodule

// File: rtl/ppx_adder.sv
module ppx_adder #(
  parameter int             N       = 32,
  parameter ppx_pkg::topo_e TOPO    = ppx_pkg::TOPO_KS,
  parameter bit             OUT_REG = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  localparam int LG         = $clog2(N);
  localparam int PFX_STAGES = ppx_pkg::pfx_levels(TOPO, LG);

  logic [N-1:0] g_w, p_w, d_w, c_w, sum_w;
  logic         cout_w;

  ppx_pg #(.N(N)) u_pg (
    .a_i  (a_i),
    .b_i  (b_i),
    .cin_i(cin_i),
    .g_o  (g_w),
    .p_o  (p_w),
    .d_o  (d_w)
  );

  ppx_tree #(.N(N), .TOPO(TOPO)) u_tree (
    .g_i(g_w),
    .p_i(p_w),
    .c_o(c_w)
  );

  ppx_sum #(.N(N)) u_sum (
    .d_i   (d_w),
    .c_i   (c_w),
    .cin_i (cin_i),
    .sum_o (sum_w),
    .cout_o(cout_w)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_o  <= '0;
        cout_o <= 1'b0;
      end else begin
        sum_o  <= sum_w;
        cout_o <= cout_w;
      end
    end
  end else begin : g_comb
    assign sum_o  = sum_w;
    assign cout_o = cout_w;
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
  end
endmodule

// File: rtl/ppx_adder_chk.sv
module ppx_adder_chk #(
  parameter int N       = 32,
  parameter bit OUT_REG = 1'b0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         cin_i,
  input logic [N-1:0] sum_o,
  input logic         cout_o
);
  logic [N:0] ref_w;
  assign ref_w = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};

  if (OUT_REG) begin : g_reg
    // R8
    reg_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> ({cout_o, sum_o} == $past(ref_w)));
    // R9
    reg_rst_chk: assert property (@(posedge clk_i)
      !rst_ni |-> (sum_o == '0 && !cout_o));
  end else begin : g_comb
    // R1
    sum_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sum_o == ref_w[N-1:0]);
    // R2
    cout_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cout_o == ref_w[N]);
  end
endmodule

bind ppx_adder ppx_adder_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/tb_ppx_adder.sv
module tb_ppx_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        cin = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [31:0] sum_r  [3][4];
  logic        cout_r [3][4];
  int          stg_r  [3][4];

  logic [15:0] rsum;
  logic        rcout;

  always #5 clk = ~clk;

  for (genvar wi = 0; wi < 3; wi++) begin : g_w
    localparam int W = 8 << wi;
    for (genvar ti = 0; ti < 4; ti++) begin : g_t
      logic [W-1:0] s;
      logic         co;
      ppx_adder #(.N(W), .TOPO(ppx_pkg::topo_e'(ti)), .OUT_REG(1'b0)) dut (
        .clk_i(clk), .rst_ni(rst_n), .a_i(a[W-1:0]), .b_i(b[W-1:0]),
        .cin_i(cin), .sum_o(s), .cout_o(co)
      );
      assign sum_r[wi][ti]  = 32'(s);
      assign cout_r[wi][ti] = co;
      assign stg_r[wi][ti]  = dut.PFX_STAGES;
    end
  end

  ppx_adder #(.N(16), .TOPO(ppx_pkg::TOPO_SK), .OUT_REG(1'b1)) dut_reg (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a[15:0]), .b_i(b[15:0]),
    .cin_i(cin), .sum_o(rsum), .cout_o(rcout)
  );

  function automatic logic [32:0] model(int w, logic [31:0] x, logic [31:0] y, logic c);
    logic [32:0] m;
    m = (33'd1 << w) - 33'd1;
    return ({1'b0, x} & m) + ({1'b0, y} & m) + {32'd0, c};
  endfunction

  task automatic check(string req, string what, logic [32:0] got, logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // every width and topology against the model and against Kogge-Stone
  task automatic check_all(string req);
    for (int wi = 0; wi < 3; wi++) begin
      int w = 8 << wi;
      logic [32:0] ref0;
      ref0 = {1'b0, sum_r[wi][0]} | ({32'd0, cout_r[wi][0]} << w);
      for (int ti = 0; ti < 4; ti++) begin
        logic [32:0] got;
        got = {1'b0, sum_r[wi][ti]} | ({32'd0, cout_r[wi][ti]} << w);
        check({req, " R1 R2 R4"}, $sformatf("w=%0d topo=%0d", w, ti), got, model(w, a, b, cin));
        check("R3", $sformatf("w=%0d topo=%0d vs ks", w, ti), got, ref0);
      end
    end
  endtask

  task automatic apply(logic [31:0] x, logic [31:0] y, logic c);
    @(negedge clk);
    a = x; b = y; cin = c;
    #1;
  endtask

  task automatic t_reset;
    #2;
    check("R9", "registered sum at reset", {16'd0, rcout, rsum}, 33'd0);
    check_all("R7 reset");
  endtask

  task automatic t_corners;
    apply('1, '0, 1'b1);       check_all("R6 all-ones carry chain");
    apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b1); check_all("R6 alternating");
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0); check_all("R6 alternating no cin");
    apply('1, '1, 1'b1);       check_all("R6 max plus max");
    apply('0, '0, 1'b1);       check_all("R6 cin only");
    apply(32'h8000_8080, 32'h8000_8080, 1'b0); check_all("R2 top carry");
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++) begin
      apply($urandom, $urandom, 1'($urandom));
      check_all("R1 random");
    end
  endtask

  task automatic t_stages;
    for (int wi = 0; wi < 3; wi++) begin
      int lg = 3 + wi;
      int exp_st [4];
      exp_st[0] = lg; exp_st[1] = 2 * lg - 1; exp_st[2] = lg; exp_st[3] = lg + 1;
      for (int ti = 0; ti < 4; ti++)
        check("R5", $sformatf("stages w=%0d topo=%0d", 8 << wi, ti),
              33'(stg_r[wi][ti]), 33'(exp_st[ti]));
    end
  endtask

  task automatic t_comb_no_clock;
    // inputs change and outputs are checked well before the next rising edge
    @(posedge clk);
    #1;
    a = 32'h1234_5678; b = 32'h0FED_CBA9; cin = 1'b1;
    #1;
    check_all("R7 no edge");
  endtask

  task automatic t_registered;
    logic [32:0] prev;
    apply(32'h0000_FFFF, 32'h0000_0001, 1'b0);
    @(negedge clk);
    check("R8", "after edge", {16'd0, rcout, rsum}, model(16, a, b, cin));
    prev = model(16, a, b, cin);
    for (int k = 0; k < 20; k++) begin
      a = $urandom; b = $urandom; cin = 1'($urandom);
      #1;
      check("R8", "held between edges", {16'd0, rcout, rsum}, prev);
      @(negedge clk);
      check("R8", "one-cycle latency", {16'd0, rcout, rsum}, model(16, a, b, cin));
      prev = model(16, a, b, cin);
    end
    #2;
    rst_n = 1'b0;
    #1;
    check("R9", "async clear", {16'd0, rcout, rsum}, 33'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_stages();
    t_corners();
    t_comb_no_clock();
    t_random();
    t_registered();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule